// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small register whose next state is chosen on every clock edge by a two-bit mode input. The four modes are keep, shift toward the left end, shift toward the right end, and parallel capture of a data word. A separate serial input feeds each shift direction. The full register contents are always visible on a parallel output, and the two end bits also appear as serial outputs, so the block can serve as a serial-to-parallel converter, a parallel-to-serial converter, or a bidirectional delay line.

The register width is a parameter and defaults to four bits. Bit `WIDTH-1` is the left end and bit 0 is the right end. An active-low clear empties the register as soon as it is asserted, without waiting for a clock edge, and it overrides every mode. The keep mode is built with a clock enable, so the whole block runs on a single free-running clock.

Top module: `usr_shift4`

## Requirements
- R1: When `mode` = 2'b00 (keep), `q` keeps its value across the clock edge.
- R2: When `mode` = 2'b10 (shift left), each bit `q[i]` with i > 0 takes the old `q[i-1]`, and `q[0]` takes `ser_in_left`.
- R3: When `mode` = 2'b01 (shift right), each bit `q[i]` with i < WIDTH-1 takes the old `q[i+1]`, and `q[WIDTH-1]` takes `ser_in_right`.
- R4: When `mode` = 2'b11 (load), `q` takes `par_in` on the clock edge.
- R5: When `clr_n` goes low, `q` becomes all zeros at once, with no clock edge needed.
- R6: While `clr_n` is low, `q` stays zero through clock edges in any mode and with any input values.
- R7: `ser_out_left` always equals `q[WIDTH-1]`, and `ser_out_right` always equals `q[0]`.
- R8: In keep mode, changes on `par_in`, `ser_in_left` and `ser_in_right` have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all updates happen on its rising edge |
| clr_n | input | 1 | Active-low clear that acts asynchronously and overrides every mode |
| mode | input | 2 | Operation select: 00 keep, 01 shift right, 10 shift left, 11 load |
| ser_in_left | input | 1 | Serial bit that enters at bit 0 during a left shift |
| ser_in_right | input | 1 | Serial bit that enters at bit WIDTH-1 during a right shift |
| par_in | input | WIDTH | Data word captured in load mode |
| q | output | WIDTH | Current register contents |
| ser_out_left | output | 1 | Left-end bit `q[WIDTH-1]` |
| ser_out_right | output | 1 | Right-end bit `q[0]` |

## Verification
The assertions check on every clock edge that each mode moves the bits as stated in R1 to R4, that the register is zero at every edge while the clear is held low (R6), and that the decoded selects are one-hot. Only the bench's scenarios can show that a clear lowered in the middle of a cycle empties the register before the next edge (R5). The bench scenarios also check the serial end outputs, and they show that inputs toggled during keep mode leave the contents alone.

// File: rtl/usr_shift_pkg.sv
// Package: shared definitions for the universal shift register.
// Assumes: the mode field is two bits wide, with bit 1 selecting left
// motion and bit 0 selecting right motion. Both bits set means load.
package usr_shift_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

    typedef struct packed {
        logic keep;
        logic left;
        logic right;
        logic load;
    } usr_sel_t;

endpackage

// File: rtl/usr_mode_decode.sv
// Module: usr_mode_decode
// Turns the two-bit mode into one-hot select lines for the bit cells.
// Assumes: the mode is stable around the clock edge. The output is purely
// combinational.
module usr_mode_decode
    import usr_shift_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic [1:0] mode,
    output usr_sel_t   sel
);

    // Decode the mode into exactly one active select.
    always_comb begin
        sel = '0;
        unique case (usr_mode_e'(mode))
            MODE_KEEP:  sel.keep  = 1'b1;
            MODE_LEFT:  sel.left  = 1'b1;
            MODE_RIGHT: sel.right = 1'b1;
            MODE_LOAD:  sel.load  = 1'b1;
            default:    sel.keep  = 1'b1;
        endcase
    end

    // R1 to R4: the bit cells rely on exactly one select being active.
    a_r1_onehot_select: assert property (@(posedge clk) disable iff (!clr_n)
        $countones(sel) == 1);

endmodule

// File: rtl/usr_bit_cell.sv
// Module: usr_bit_cell
// Works out the next value of one register bit from its neighbours, the
// parallel data bit and the decoded mode.
// Assumes: the selects are one-hot. The keep case is handled by the clock
// enable in the parent, so in that case the output here is don't-care.
module usr_bit_cell
    import usr_shift_pkg::*;
(
    input  usr_sel_t sel,
    input  logic     from_right,
    input  logic     from_left,
    input  logic     load_bit,
    input  logic     cur_bit,
    output logic     nxt_bit
);

    // Steer one of the three sources, or the bit itself, to the next value.
    always_comb begin
        if (sel.load)       nxt_bit = load_bit;
        else if (sel.left)  nxt_bit = from_right;
        else if (sel.right) nxt_bit = from_left;
        else                nxt_bit = cur_bit;
    end

endmodule

// File: rtl/usr_shift4.sv
// Module: usr_shift4
// Universal shift register with keep, shift left, shift right and load.
// Bit WIDTH-1 is the left end. The clear is active low and asynchronous,
// and it has priority over every mode.
// Assumes: a single free-running clock. Keep mode is done with an enable,
// never by gating the clock.
module usr_shift4
    import usr_shift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_in_left,
    input  logic             ser_in_right,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out_left,
    output logic             ser_out_right
);

    localparam int TOP = WIDTH - 1;

    usr_sel_t         sel;
    logic [WIDTH-1:0] nxt;
    logic             upd_en;

    usr_mode_decode i_decode (
        .clk   (clk),
        .clr_n (clr_n),
        .mode  (mode),
        .sel   (sel)
    );

    // One steering cell per bit; the end bits take the serial inputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic rgt_src;
        logic lft_src;
        if (i == 0) begin : g_rend
            assign rgt_src = ser_in_left;
        end else begin : g_rmid
            assign rgt_src = q[i-1];
        end
        if (i == TOP) begin : g_lend
            assign lft_src = ser_in_right;
        end else begin : g_lmid
            assign lft_src = q[i+1];
        end
        usr_bit_cell i_cell (
            .sel        (sel),
            .from_right (rgt_src),
            .from_left  (lft_src),
            .load_bit   (par_in[i]),
            .cur_bit    (q[i]),
            .nxt_bit    (nxt[i])
        );
    end

    // The enable replaces a gated clock in keep mode.
    assign upd_en = !sel.keep;

    // Register state: cleared at once by clr_n, otherwise updated when enabled.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      q <= '0;
        else if (upd_en) q <= nxt;
    end

    // Drive the end bits out as serial outputs.
    assign ser_out_left  = q[TOP];
    assign ser_out_right = q[0];

    // R1: keep mode leaves the contents unchanged.
    a_r1_keep_stable: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b00 |=> $stable(q));
    // R2: shift left moves bits up and brings in ser_in_left at bit 0.
    a_r2_shift_left: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b10 |=> q == {$past(q[TOP-1:0]), $past(ser_in_left)});
    // R3: shift right moves bits down and brings in ser_in_right at the top.
    a_r3_shift_right: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b01 |=> q == {$past(ser_in_right), $past(q[TOP:1])});
    // R4: load captures the parallel word.
    a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b11 |=> q == $past(par_in));
    // R6: the register is zero at every edge while the clear is held low.
    a_r6_clear_wins: assert property (@(posedge clk)
        !clr_n |-> q == '0);

endmodule

// File: tb/test_usr_shift4.sv
module test_usr_shift4;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         ser_in_left = 1'b0;
    logic         ser_in_right = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q;
    logic         ser_out_left;
    logic         ser_out_right;

    int n_run  = 0;
    int n_fail = 0;

    usr_shift4 #(.WIDTH(W)) i_usr_shift4 (
        .clk           (clk),
        .clr_n         (clr_n),
        .mode          (mode),
        .ser_in_left   (ser_in_left),
        .ser_in_right  (ser_in_right),
        .par_in        (par_in),
        .q             (q),
        .ser_out_left  (ser_out_left),
        .ser_out_right (ser_out_right)
    );

    always #5 clk = ~clk;

    // Each vector holds {mode, ser_in_left, ser_in_right, par_in, expected q}.
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {2'b11, 1'b0, 1'b0, 4'b1011, 4'b1011}, // R4 load
        {2'b00, 1'b1, 1'b1, 4'b0100, 4'b1011}, // R1, R8 keep
        {2'b10, 1'b0, 1'b1, 4'b1111, 4'b0110}, // R2 left, 0 enters
        {2'b10, 1'b1, 1'b0, 4'b0000, 4'b1101}, // R2 left, 1 enters
        {2'b01, 1'b1, 1'b0, 4'b1111, 4'b0110}, // R3 right, 0 enters
        {2'b01, 1'b0, 1'b1, 4'b0000, 4'b1011}, // R3 right, 1 enters
        {2'b11, 1'b1, 1'b1, 4'b0000, 4'b0000}, // R4 load zero
        {2'b01, 1'b0, 1'b1, 4'b0000, 4'b1000}, // R3
        {2'b01, 1'b0, 1'b1, 4'b0000, 4'b1100}, // R3
        {2'b10, 1'b0, 1'b0, 4'b0000, 4'b1000}, // R2
        {2'b00, 1'b1, 1'b1, 4'b1111, 4'b1000}, // R8 inputs ignored
        {2'b11, 1'b0, 1'b0, 4'b0101, 4'b0101}  // R4
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        #100000;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R5: clear with no clock edge yet.
        #1 clr_n = 1'b0;
        #1 check("R5 reset state", q, 4'b0000);
        @(negedge clk) clr_n = 1'b1;

        // Walk the vector table: drive at negedge, sample two ns after posedge.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {mode, ser_in_left, ser_in_right, par_in} = VEC[k][11:4];
            @(posedge clk);
            #2;
            check($sformatf("R1-4 vector %0d", k), q, VEC[k][3:0]);
            check("R7 serial outputs", {2'b00, ser_out_left, ser_out_right},
                  {2'b00, VEC[k][3], VEC[k][0]});
        end

        // R5: clear in the middle of a cycle takes effect before the next edge.
        @(negedge clk);
        mode = 2'b11; par_in = 4'b1111;
        @(posedge clk); #2;
        check("R4 load ones", q, 4'b1111);
        #1 clr_n = 1'b0;
        #1 check("R5 mid-cycle clear", q, 4'b0000);

        // R6: clear held low across edges beats load and shift modes.
        @(posedge clk); #2;
        check("R6 clear over load", q, 4'b0000);
        mode = 2'b01; ser_in_right = 1'b1;
        @(posedge clk); #2;
        check("R6 clear over shift right", q, 4'b0000);
        check("R7 serial outputs cleared", {2'b00, ser_out_left, ser_out_right}, 4'b0000);

        // Release the clear, then shift right once to prove normal operation resumes.
        @(negedge clk) clr_n = 1'b1;
        @(posedge clk); #2;
        check("R3 after clear release", q, 4'b1000);

        // R8: toggle every input during keep mode and watch the contents.
        @(negedge clk);
        mode = 2'b00;
        for (int t = 0; t < 3; t++) begin
            par_in = 4'(t * 5 + 3); ser_in_left = t[0]; ser_in_right = ~t[0];
            @(posedge clk); #2;
            check("R8 keep ignores inputs", q, 4'b1000);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule